// File: doc/BRIEF.md
# Codec Control-Register Command Port

This block handles the control path between a host processor and an audio codec's configuration registers. The host first places a data word in a transmit data register. It then writes a command word to a transmit command register. Storing the command word starts exactly one codec register transaction on a simple request/acknowledge port. That transaction is either a write of the staged data or a read of a codec register.

When a read finishes, the block keeps two results for the host: the command with its direction bit cleared, and the returned 16-bit value placed in the upper bits of a 20-bit word. A flag register tracks the state of the exchange. It shows whether each transmit register is free, whether a read answer is pending, and whether a read answer is waiting to be collected.

The host side is a strobe-based register port with a one-cycle registered read return. The codec side holds a request until the codec acknowledges it. Audio sample slots and serial framing lie outside this block.

Top module: `codec_cmd_port`

## Requirements
- R1: After reset the flag word (select 4) reads 0x07: bit0 command-transmit-empty, bit1 data-transmit-empty and bit2 both-transmit-empty are set. Bit3 command-receive-busy, bit4 data-receive-busy, bit5 command-receive-valid and bit6 data-receive-valid are clear. The codec request is low and the receive registers read zero.
- R2: A host write to select 1 (transmit data) stores the 20-bit word and clears flag bits 1 and 2. Flag bit 0 is not changed.
- R3: A host write to select 0 (transmit command) with bit 19 clear, while no request is pending, raises the codec request on the next cycle with write-enable high. The address is command bits 18:12 and the write data is bits 19:4 of the transmit data register. Flag bits 0 and 2 are cleared.
- R4: A command with bit 19 set issues a codec read (write-enable low) to address bits 18:12 and sets flag bits 3 and 4 while the read is pending.
- R5: When a read is acknowledged, select 2 then returns the command word with bit 19 cleared and select 3 returns the codec read data shifted left by 4. Flag bits 3 and 4 clear and flag bits 5 and 6 set.
- R6: The request stays high, with address, direction and write data unchanged, until a cycle in which acknowledge is high. In the next cycle the request is low and flag bits 0, 1 and 2 are set.
- R7: A command write made while a request is pending is ignored. It issues no further request, does not alter the pending one and is not stored in the transmit command register.
- R8: A host read of select 2 clears flag bits 5 and 6. A read of select 3 leaves them set.
- R9: Completion of a codec write changes neither the receive registers nor flag bits 5 and 6.
- R10: A host read strobe returns the selected register one cycle later with the read-valid output high. Selects 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 3 | Register select: 0 command, 1 data, 2 received command, 3 received data, 4 flags |
| host_wdata | input | 20 | Host write word |
| host_rdata | output | 20 | Registered read word |
| host_rvalid | output | 1 | High for the cycle host_rdata holds a read result |
| cdc_req | output | 1 | Codec transaction request, held until acknowledged |
| cdc_we | output | 1 | 1 for a codec register write, 0 for a read |
| cdc_addr | output | 7 | Codec register address |
| cdc_wdata | output | 16 | Codec register write data |
| cdc_ack | input | 1 | Codec acknowledge, completes the request in the same cycle |
| cdc_rdata | input | 16 | Codec read data, valid with cdc_ack on a read |

## Verification
A wrong transaction state shows up directly at the codec port. A lost or duplicated launch, a request that drops before acknowledge, or fields that move while the request is held can all be seen there in the cycle after the host write or after the acknowledge. Wrong flag or receive-register state stays hidden until the host reads it back. For that reason the bench reads the flag word at each phase: before launch, while a read is pending, after completion and after collection. A stale valid bit or a busy bit that never clears is then reported within a couple of cycles of the event that should have changed it.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [2:0] {
    SEL_CMD     = 3'd0,
    SEL_DATA    = 3'd1,
    SEL_RX_CMD  = 3'd2,
    SEL_RX_DATA = 3'd3,
    SEL_FLAGS   = 3'd4
  } host_sel_e;

  typedef struct packed {
    logic data_rx_valid;
    logic cmd_rx_valid;
    logic data_rx_busy;
    logic cmd_rx_busy;
    logic all_tx_empty;
    logic data_tx_empty;
    logic cmd_tx_empty;
  } slot_flags_t;

  localparam int FLAG_W = $bits(slot_flags_t);

endpackage

// File: rtl/ccp_tx_regs.sv
module ccp_tx_regs
  import ccp_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [SLOT_W-1:0] wdata,
  input  logic              pending,
  input  logic              done,
  output logic              launch,
  output logic [SLOT_W-1:0] cmd_q,
  output logic [SLOT_W-1:0] data_q,
  output logic              cmd_empty,
  output logic              data_empty
);

  logic wr_cmd, wr_data;

  always_comb begin
    wr_cmd  = wr && (sel == SEL_W'(SEL_CMD));
    wr_data = wr && (sel == SEL_W'(SEL_DATA));
    launch  = wr_cmd && !pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      cmd_empty <= 1'b1;
    end else if (launch) begin
      cmd_q     <= wdata;
      cmd_empty <= 1'b0;
    end else if (done) begin
      cmd_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      data_empty <= 1'b1;
    end else if (wr_data) begin
      data_q     <= wdata;
      data_empty <= 1'b0;
    end else if (done) begin
      data_empty <= 1'b1;
    end
  end

endmodule

// File: rtl/ccp_req_ctrl.sv
module ccp_req_ctrl #(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [SLOT_W-1:0] cmd_word,
  input  logic [SLOT_W-1:0] data_word,
  input  logic              cdc_ack,
  output logic              cdc_req,
  output logic              cdc_we,
  output logic [ADDR_W-1:0] cdc_addr,
  output logic [DATA_W-1:0] cdc_wdata,
  output logic              done,
  output logic              done_rd,
  output logic              launch_rd
);

  localparam int RW_BIT  = SLOT_W - 1;
  localparam int ADDR_HI = SLOT_W - 2;

  typedef enum logic {ST_IDLE, ST_WAIT} req_state_e;
  req_state_e state_q;

  always_comb begin
    done      = (state_q == ST_WAIT) && cdc_ack;
    done_rd   = done && !cdc_we;
    launch_rd = launch && cmd_word[RW_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cdc_req   <= 1'b0;
      cdc_we    <= 1'b0;
      cdc_addr  <= '0;
      cdc_wdata <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch) begin
          state_q   <= ST_WAIT;
          cdc_req   <= 1'b1;
          cdc_we    <= !cmd_word[RW_BIT];
          cdc_addr  <= cmd_word[ADDR_HI -: ADDR_W];
          cdc_wdata <= data_word[RW_BIT -: DATA_W];
        end
        ST_WAIT: if (cdc_ack) begin
          state_q <= ST_IDLE;
          cdc_req <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ccp_rx_regs.sv
module ccp_rx_regs #(
  parameter int SLOT_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_rd,
  input  logic              done_rd,
  input  logic              clr_valid,
  input  logic [SLOT_W-1:0] cmd_word,
  input  logic [DATA_W-1:0] cdc_rdata,
  output logic [SLOT_W-1:0] rx_cmd,
  output logic [SLOT_W-1:0] rx_data,
  output logic              busy,
  output logic              valid
);

  localparam int RW_BIT = SLOT_W - 1;
  localparam int PAD_W  = SLOT_W - DATA_W;

  logic [SLOT_W-1:0] rw_mask;
  assign rw_mask = ~(SLOT_W'(1) << RW_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cmd  <= '0;
      rx_data <= '0;
    end else if (done_rd) begin
      rx_cmd  <= cmd_word & rw_mask;
      rx_data <= {cdc_rdata, {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      valid <= 1'b0;
    end else begin
      if (launch_rd)    busy <= 1'b1;
      else if (done_rd) busy <= 1'b0;
      if (done_rd)        valid <= 1'b1;
      else if (clr_valid) valid <= 1'b0;
    end
  end

endmodule

// File: rtl/codec_cmd_port.sv
module codec_cmd_port
  import ccp_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [SLOT_W-1:0] host_wdata,
  output logic [SLOT_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              cdc_req,
  output logic              cdc_we,
  output logic [ADDR_W-1:0] cdc_addr,
  output logic [DATA_W-1:0] cdc_wdata,
  input  logic              cdc_ack,
  input  logic [DATA_W-1:0] cdc_rdata
);

  localparam int FLAG_PAD = SLOT_W - FLAG_W;

  logic              launch, done, done_rd, launch_rd;
  logic [SLOT_W-1:0] cmd_q, data_q, rx_cmd, rx_data;
  logic              cmd_empty, data_empty, rx_busy, rx_valid, clr_valid;
  slot_flags_t       flag_q;

  assign clr_valid = host_rd && (host_sel == SEL_W'(SEL_RX_CMD));

  ccp_tx_regs #(.SLOT_W(SLOT_W), .SEL_W(SEL_W)) u_tx (
    .clk(clk), .rst(rst), .wr(host_wr), .sel(host_sel), .wdata(host_wdata),
    .pending(cdc_req), .done(done), .launch(launch),
    .cmd_q(cmd_q), .data_q(data_q),
    .cmd_empty(cmd_empty), .data_empty(data_empty)
  );

  ccp_req_ctrl #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .launch(launch),
    .cmd_word(host_wdata), .data_word(data_q), .cdc_ack(cdc_ack),
    .cdc_req(cdc_req), .cdc_we(cdc_we), .cdc_addr(cdc_addr),
    .cdc_wdata(cdc_wdata), .done(done), .done_rd(done_rd),
    .launch_rd(launch_rd)
  );

  ccp_rx_regs #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .launch_rd(launch_rd), .done_rd(done_rd),
    .clr_valid(clr_valid), .cmd_word(cmd_q), .cdc_rdata(cdc_rdata),
    .rx_cmd(rx_cmd), .rx_data(rx_data), .busy(rx_busy), .valid(rx_valid)
  );

  always_comb begin
    flag_q.cmd_tx_empty  = cmd_empty;
    flag_q.data_tx_empty = data_empty;
    flag_q.all_tx_empty  = cmd_empty && data_empty;
    flag_q.cmd_rx_busy   = rx_busy;
    flag_q.data_rx_busy  = rx_busy;
    flag_q.cmd_rx_valid  = rx_valid;
    flag_q.data_rx_valid = rx_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) begin
        case (host_sel)
          SEL_W'(SEL_CMD):     host_rdata <= cmd_q;
          SEL_W'(SEL_DATA):    host_rdata <= data_q;
          SEL_W'(SEL_RX_CMD):  host_rdata <= rx_cmd;
          SEL_W'(SEL_RX_DATA): host_rdata <= rx_data;
          SEL_W'(SEL_FLAGS):   host_rdata <= {{FLAG_PAD{1'b0}}, flag_q};
          default:             host_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/ccp_checker.sv
module ccp_checker
  import ccp_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic             host_rd,
  input logic [SEL_W-1:0] host_sel,
  input logic             cdc_req,
  input logic             cdc_we,
  input logic [6:0]       cdc_addr,
  input logic             cdc_ack,
  input slot_flags_t      flag_q
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flag_q == 7'h07) && !cdc_req);

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel == SEL_W'(SEL_CMD) && !cdc_req) |=> cdc_req);

  // R4
  busy_pending_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q.cmd_rx_busy |-> (cdc_req && !cdc_we));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cdc_req && !cdc_ack) |=> cdc_req && $stable(cdc_addr) && $stable(cdc_we));

  // R6
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cdc_req && cdc_ack) |=> !cdc_req && flag_q.cmd_tx_empty);

  // R5
  rd_done_chk: assert property (@(posedge clk) disable iff (rst)
    (cdc_req && cdc_ack && !cdc_we) |=>
      flag_q.cmd_rx_valid && flag_q.data_rx_valid && !flag_q.cmd_rx_busy);

  // R8
  valid_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_sel == SEL_W'(SEL_RX_CMD) && !(cdc_req && cdc_ack)) |=>
      !flag_q.cmd_rx_valid);

endmodule

bind codec_cmd_port ccp_checker #(.SEL_W(SEL_W)) i_ccp_checker (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_sel(host_sel), .cdc_req(cdc_req), .cdc_we(cdc_we),
  .cdc_addr(cdc_addr), .cdc_ack(cdc_ack), .flag_q(flag_q)
);

// File: tb/test_codec_cmd_port.sv
module test_codec_cmd_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_sel = '0;
  logic [19:0] host_wdata = '0;
  logic [19:0] host_rdata;
  logic        host_rvalid;
  logic        cdc_req, cdc_we, cdc_ack = 1'b0;
  logic [6:0]  cdc_addr;
  logic [15:0] cdc_wdata, cdc_rdata = '0;

  always #2.5 clk = ~clk;

  codec_cmd_port i_codec_cmd_port (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .cdc_req(cdc_req), .cdc_we(cdc_we),
    .cdc_addr(cdc_addr), .cdc_wdata(cdc_wdata), .cdc_ack(cdc_ack),
    .cdc_rdata(cdc_rdata)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int ack_delay = 2;

  typedef struct { logic [19:0] val; string tag; } rd_exp_t;
  typedef struct { logic we; logic [6:0] addr; logic [15:0] wd; string tag; } req_exp_t;
  rd_exp_t  rd_q[$];
  req_exp_t req_q[$];
  logic [15:0] model [128];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [2:0] sel, input logic [19:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] sel, input logic [19:0] exp, input string tag);
    rd_exp_t e;
    e.val = exp; e.tag = tag;
    rd_q.push_back(e);
    host_rd = 1'b1; host_sel = sel;
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_req(input logic we, input logic [6:0] a, input logic [15:0] wd,
                            input string tag);
    req_exp_t r;
    r.we = we; r.addr = a; r.wd = wd; r.tag = tag;
    req_q.push_back(r);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (cdc_req) @(negedge clk);
  endtask

  // read-result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (host_rvalid) begin
        if (rd_q.size() == 0) check(1'b0, "R10 unexpected rvalid", 1, 0);
        else begin
          rd_exp_t e;
          e = rd_q.pop_front();
          check(host_rdata == e.val, e.tag, host_rdata, e.val);
        end
      end
    end
  end

  // codec responder and request scoreboard
  initial begin
    for (int i = 0; i < 128; i++) model[i] = 16'(i * 16'h0101);
    forever begin
      @(negedge clk);
      if (cdc_req) begin
        logic        c_we;
        logic [6:0]  c_addr;
        logic [15:0] c_wd;
        c_we = cdc_we; c_addr = cdc_addr; c_wd = cdc_wdata;
        if (req_q.size() == 0) check(1'b0, "R7 unexpected codec request", c_addr, 0);
        else begin
          req_exp_t r;
          r = req_q.pop_front();
          check(c_we == r.we, {r.tag, " direction"}, c_we, r.we);
          check(c_addr == r.addr, {r.tag, " address"}, c_addr, r.addr);
          if (r.we) check(c_wd == r.wd, {r.tag, " write data"}, c_wd, r.wd);
        end
        repeat (ack_delay) @(negedge clk);
        check(cdc_req && cdc_addr == c_addr && cdc_we == c_we,
              "R6 request held stable", {cdc_req, cdc_addr}, {1'b1, c_addr});
        if (c_we) model[c_addr] = c_wd;
        else cdc_rdata = model[c_addr];
        cdc_ack = 1'b1;
        @(negedge clk);
        cdc_ack = 1'b0;
        check(!cdc_req, "R6 request dropped after ack", cdc_req, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!cdc_req, "R1 request low after reset", cdc_req, 0);
    cpu_read(3'd4, 20'h00007, "R1 flags after reset");
    cpu_read(3'd2, 20'h0, "R1 rx command after reset");
    cpu_read(3'd3, 20'h0, "R1 rx data after reset");

    // R2
    cpu_write(3'd1, 20'hABCD0);
    cpu_read(3'd4, 20'h00001, "R2 flags after data write");

    // R3 codec write
    expect_req(1'b1, 7'h15, 16'hABCD, "R3 write request");
    cpu_write(3'd0, 20'h15000);
    cpu_read(3'd4, 20'h00000, "R3 flags while write pending");
    wait_idle();
    cpu_read(3'd4, 20'h00007, "R6 flags after write completion");
    cpu_read(3'd2, 20'h0, "R9 rx command unchanged by write");

    // R4/R5 codec read
    ack_delay = 5;
    expect_req(1'b0, 7'h15, 16'h0, "R4 read request");
    cpu_write(3'd0, 20'h95003);
    cpu_read(3'd4, 20'h0001A, "R4 busy flags while read pending");
    wait_idle();
    cpu_read(3'd3, 20'hABCD0, "R5 rx data shifted");
    cpu_read(3'd4, 20'h00067, "R8 valid kept after rx data read");
    cpu_read(3'd2, 20'h15003, "R5 rx command with read bit cleared");
    cpu_read(3'd4, 20'h00007, "R8 valid cleared by rx command read");

    // R7 command during pending request
    ack_delay = 7;
    cpu_write(3'd1, 20'h12340);
    expect_req(1'b1, 7'h22, 16'h1234, "R7 first request");
    cpu_write(3'd0, 20'h22000);
    cpu_write(3'd0, 20'h95000);
    cpu_write(3'd1, 20'h55550);
    wait_idle();
    repeat (4) @(negedge clk);
    check(!cdc_req, "R7 no second request", cdc_req, 0);
    cpu_read(3'd0, 20'h22000, "R7 command register kept");
    cpu_read(3'd4, 20'h00007, "R9 flags after write, no valid");

    // R10
    cpu_read(3'd6, 20'h0, "R10 unused select reads zero");
    cpu_read(3'd1, 20'h55550, "R10 data register readback");

    // fast acknowledge, read back written register
    ack_delay = 0;
    expect_req(1'b0, 7'h22, 16'h0, "R4 read of written register");
    cpu_write(3'd0, 20'hA2ABC);
    wait_idle();
    cpu_read(3'd2, 20'h22ABC, "R5 rx command low bits kept");
    cpu_read(3'd3, 20'h12340, "R5 rx data from written value");

    // all-ones pattern
    ack_delay = 3;
    cpu_write(3'd1, 20'hFFFFF);
    expect_req(1'b1, 7'h7F, 16'hFFFF, "R3 all-ones write");
    cpu_write(3'd0, 20'h7F000);
    wait_idle();
    expect_req(1'b0, 7'h7F, 16'h0, "R4 all-ones read");
    cpu_write(3'd0, 20'hFF00F);
    wait_idle();
    cpu_read(3'd3, 20'hFFFF0, "R5 rx data all ones");
    cpu_read(3'd2, 20'h7F00F, "R5 rx command all-ones address");
    cpu_read(3'd4, 20'h00007, "R8 flags after collection");

    repeat (4) @(negedge clk);
    check(rd_q.size() == 0 && req_q.size() == 0, "R10 all expected items seen",
          rd_q.size() + req_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule